// File: doc/BRIEF.md
# Two-Wire Serial Byte-Write Memory Slave

This block is the target side of a two-wire serial memory: a clock line driven by the bus master, and a shared open-drain data line. It samples both lines into the system clock domain and finds start and stop conditions. It decodes the device-select byte against a fixed `1010` prefix and three strap inputs. For a write it then takes a two-byte word address (high byte first) and one data byte into an on-chip byte array. Each byte it accepts is acknowledged by pulling the data line low through an output-enable signal.

The array is updated only when the master closes the transfer with a stop condition. The block then runs a timed busy period, counted in system clock cycles, and ignores the bus completely until it ends. A write-protect input, checked at the stop condition, suppresses both the array update and the busy period. The rest of the chip reads the array through a plain combinational read port.

Top module: `eeprom_wr_slave`

## Requirements
- R1: A device-select byte is acknowledged (data line pulled low during the ninth clock) only when its bits [7:4] equal 1010 and its bits [3:1] equal `strap_i`. On a mismatch nothing is acknowledged, and later bytes are not acknowledged until the next start.
- R2: Bit 0 of the device-select byte chooses the operation, with 0 for write and 1 for read. A matching read-select byte is acknowledged, but the bytes that follow it are not acknowledged and nothing is written.
- R3: After a matching write-select byte, the word-address high byte, the word-address low byte and the data byte are each acknowledged. A fifth byte is not acknowledged. The array location is the low ADDR_W bits of the 16-bit word address {high, low}.
- R4: The array is written only on the stop condition that ends a transfer carrying a data byte. A transfer stopped before its data byte writes nothing and starts no busy period.
- R5: A start condition in the middle of a transfer restarts device-select decoding, and the partial transfer is discarded.
- R6: After a committed write, `busy_o` is high for exactly TWR_CYCLES consecutive clock cycles.
- R7: While `busy_o` is high, the slave acknowledges nothing and ignores start conditions. A transfer whose start fell inside the busy period stays unacknowledged after busy ends, until a new start arrives.
- R8: If `wp_i` is high at the stop condition, the data byte has still been acknowledged, but the array keeps its value and `busy_o` stays low.
- R9: `sda_oe_o` changes only while the synchronized clock line is low.
- R10: After reset `busy_o` and `sda_oe_o` are low and every array location reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (resolved bus) |
| strap_i | input | 3 | Hard-wired device-select strap bits |
| wp_i | input | 1 | Write protect; high blocks array updates |
| sda_oe_o | output | 1 | Pull data line low when high, release otherwise |
| busy_o | output | 1 | Timed write cycle in progress |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | 8 | Array contents at `rd_addr_i` |

## Verification
The assertions check on every cycle that the data-line pull-down moves only while the clock line is low, that it is never active during the busy period, that no write is accepted while busy, that a write always opens a busy period, that busy never rises under write protect, and that every busy period lasts exactly TWR_CYCLES. Which bytes are acknowledged, how the device-select byte is decoded against the straps, where data lands in the array, and how repeated starts, extra bytes and transfers begun while busy are handled depend on whole bus sequences. Only the bench's scenarios can show these: an exhaustive sweep of all 256 device-select values, and writes to every location of a 16-byte array.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    // byte position within a transfer
    localparam logic [2:0] BYTE_DEV   = 3'd0;
    localparam logic [2:0] BYTE_AHI   = 3'd1;
    localparam logic [2:0] BYTE_ALO   = 3'd2;
    localparam logic [2:0] BYTE_DATA  = 3'd3;
    localparam logic [2:0] BYTE_EXTRA = 3'd4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_DECIDE,
        PH_ACK,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic dev_match(input logic [7:0] b, input logic [2:0] strap);
        return (b[7:4] == DEV_PREFIX) && (b[3:1] == strap);
    endfunction

endpackage

// File: rtl/i2cs_line_watch.sv
module i2cs_line_watch
    import eeprom_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
    logic scl_q, sda_q;
    logic scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_p  <= scl_q;
            sda_p  <= sda_q;
        end
    end

    assign scl_q = scl_sh[SYNC_STAGES-1];
    assign sda_q = sda_sh[SYNC_STAGES-1];

    always_comb begin
        ev.scl      = scl_q;
        ev.sda      = sda_q;
        ev.scl_rise = scl_q & ~scl_p;
        ev.scl_fall = ~scl_q & scl_p;
        ev.start    = scl_q & scl_p & sda_p & ~sda_q;
        ev.stop     = scl_q & scl_p & ~sda_p & sda_q;
    end
endmodule

// File: rtl/i2cs_xfer_ctrl.sv
module i2cs_xfer_ctrl
    import eeprom_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [2:0]        strap_i,
    input  logic              busy_i,
    output logic              sda_oe,
    output logic              commit,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    phase_e     phase;
    logic [2:0] bitcnt;
    logic [2:0] idx;
    logic [7:0] shreg;
    logic       rd_sel;
    logic       pend;
    logic       ack_ok;

    always_comb begin
        case (idx)
            BYTE_DEV:                      ack_ok = dev_match(shreg, strap_i);
            BYTE_AHI, BYTE_ALO, BYTE_DATA: ack_ok = 1'b1;
            default:                       ack_ok = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            bitcnt  <= '0;
            idx     <= BYTE_DEV;
            shreg   <= '0;
            rd_sel  <= 1'b0;
            pend    <= 1'b0;
            sda_oe  <= 1'b0;
            commit  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            commit <= 1'b0;
            if (busy_i) begin
                phase  <= PH_IDLE;
                sda_oe <= 1'b0;
                pend   <= 1'b0;
            end else if (ev.stop) begin
                phase  <= PH_IDLE;
                sda_oe <= 1'b0;
                commit <= pend;
                pend   <= 1'b0;
            end else if (ev.start) begin
                phase  <= PH_RX;
                bitcnt <= '0;
                idx    <= BYTE_DEV;
                rd_sel <= 1'b0;
                pend   <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                case (phase)
                    PH_RX: if (ev.scl_rise) begin
                        shreg  <= {shreg[6:0], ev.sda};
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) phase <= PH_DECIDE;
                    end
                    PH_DECIDE: if (ev.scl_fall) begin
                        if (ack_ok) begin
                            sda_oe <= 1'b1;
                            phase  <= PH_ACK;
                            case (idx)
                                BYTE_DEV:  rd_sel  <= shreg[0];
                                BYTE_DATA: begin
                                    wr_data <= shreg;
                                    pend    <= 1'b1;
                                end
                                default:   wr_addr <= ADDR_W'({wr_addr, shreg});
                            endcase
                        end else begin
                            phase <= PH_SKIP;
                        end
                    end
                    PH_ACK: if (ev.scl_fall) begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        if (idx != BYTE_EXTRA) idx <= idx + 3'd1;
                        phase  <= rd_sel ? PH_SKIP : PH_RX;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cs_busy_timer.sv
module i2cs_busy_timer #(
    parameter int TWR_CYCLES = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    localparam int CW = $clog2(TWR_CYCLES + 1);
    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)              remain <= '0;
        else if (load)        remain <= CW'(TWR_CYCLES);
        else if (remain != 0) remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/i2cs_byte_array.sv
module i2cs_byte_array #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/eeprom_wr_slave.sv
module eeprom_wr_slave
    import eeprom_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int TWR_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap_i,
    input  logic              wp_i,
    output logic              sda_oe_o,
    output logic              busy_o,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o
);
    bus_ev_t           ev;
    logic              commit;
    logic              mem_we;
    logic              scl_s;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;

    i2cs_line_watch #(.SYNC_STAGES(2)) u_watch (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    i2cs_xfer_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst(rst), .ev(ev), .strap_i(strap_i), .busy_i(busy_o),
        .sda_oe(sda_oe_o), .commit(commit), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    assign mem_we = commit & ~wp_i;
    assign scl_s  = ev.scl;

    i2cs_busy_timer #(.TWR_CYCLES(TWR_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .load(mem_we), .busy(busy_o)
    );

    i2cs_byte_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst(rst), .we(mem_we), .waddr(wr_addr), .wdata(wr_data),
        .raddr(rd_addr_i), .rdata(rd_data_o)
    );
endmodule

// File: rtl/eeprom_wr_slave_chk.sv
module eeprom_wr_slave_chk #(
    parameter int TWR_CYCLES = 200
) (
    input logic clk,
    input logic rst,
    input logic scl_s,
    input logic sda_oe_o,
    input logic busy_o,
    input logic wp_i,
    input logic mem_we
);
    int run_len;

    always_ff @(posedge clk) begin
        if (rst)         run_len <= 0;
        else if (busy_o) run_len <= run_len + 1;
        else             run_len <= 0;
    end

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_s)); // R9
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !sda_oe_o); // R7
    AST_NO_WE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !busy_o); // R7
    AST_WE_OPENS_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> busy_o); // R4
    AST_WP_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> !$past(wp_i)); // R8
    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (run_len == TWR_CYCLES)); // R6
endmodule

bind eeprom_wr_slave eeprom_wr_slave_chk #(.TWR_CYCLES(TWR_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_oe_o(sda_oe_o),
    .busy_o(busy_o), .wp_i(wp_i), .mem_we(mem_we)
);

// File: tb/eeprom_wr_slave_tb.sv
module eeprom_wr_slave_tb;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int TWR   = 40;
    localparam int Q     = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          scl_m = 1'b1;
    logic          sda_m = 1'b1;
    logic          wp = 1'b0;
    logic [2:0]    strap = 3'd5;
    logic [AW-1:0] rd_addr = '0;
    logic          sda_oe, busy, sda_line;
    logic [7:0]    rd_data;

    assign sda_line = sda_m & ~sda_oe;

    eeprom_wr_slave #(.ADDR_W(AW), .TWR_CYCLES(TWR)) u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .strap_i(strap),
        .wp_i(wp), .sda_oe_o(sda_oe), .busy_o(busy),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    always #10 clk = ~clk;

    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;
    logic [7:0] exp_mem [DEPTH];

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hold(Q);
            scl_m = 1'b1; hold(2 * Q);
            scl_m = 1'b0; hold(Q);
        end
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        ack = !sda_line;
        hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    // count busy cycles in a window starting at the stop condition
    task automatic busy_len(output int len);
        len = 0;
        for (int i = 0; i < TWR + 30; i++) begin
            @(negedge clk);
            if (busy) len++;
        end
    endtask

    task automatic peek(input int a, output int v);
        rd_addr = AW'(a);
        @(negedge clk);
        v = int'(rd_data);
    endtask

    task automatic write_cycle(input logic [7:0] dev, input logic [7:0] ahi,
                               input logic [7:0] alo, input logic [7:0] dat,
                               output bit [3:0] acks, output int len);
        bit a;
        bus_start;
        send_byte(dev, a); acks[3] = a;
        send_byte(ahi, a); acks[2] = a;
        send_byte(alo, a); acks[1] = a;
        send_byte(dat, a); acks[0] = a;
        bus_stop;
        busy_len(len);
    endtask

    function automatic logic [7:0] wdev(input logic [2:0] s);
        return {4'b1010, s, 1'b0};
    endfunction

    initial begin
        bit       a;
        bit [3:0] acks;
        int       len, v;

        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'h00;
        hold(5);
        rst = 1'b0;
        hold(2);

        // R10: reset state
        check_eq("R10 busy after reset", int'(busy), 0);
        check_eq("R10 sda_oe after reset", int'(sda_oe), 0);
        for (int i = 0; i < DEPTH; i++) begin
            peek(i, v);
            check_eq("R10 array zero after reset", v, 0);
        end

        // R1/R2: exhaustive device-select sweep
        for (int d = 0; d < 256; d++) begin
            logic [7:0] db;
            db = 8'(d);
            bus_start;
            send_byte(db, a);
            bus_stop;
            hold(2 * Q);
            check_eq("R1 R2 device-select ack", int'(a),
                     int'((db[7:4] == 4'hA) && (db[3:1] == strap)));
        end

        // R1: strap sweep, matching byte acked for each strap setting
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            bus_start;
            send_byte(wdev(3'(s)), a);
            bus_stop;
            hold(2 * Q);
            check_eq("R1 strap match ack", int'(a), 1);
            bus_start;
            send_byte(wdev(3'(s ^ 1)), a);
            bus_stop;
            hold(2 * Q);
            check_eq("R1 strap mismatch nack", int'(a), 0);
        end
        strap = 3'd5;

        // R3/R4/R6: write every location; upper address bits are ignored
        for (int l = 0; l < DEPTH; l++) begin
            logic [7:0] dat, ahi, alo;
            dat = 8'((l * 37 + 11) & 255);
            ahi = 8'((l * 29 + 3) & 255);
            alo = {4'(l + 3), 4'(l)};
            write_cycle(wdev(strap), ahi, alo, dat, acks, len);
            exp_mem[l] = dat;
            check_eq("R3 all four bytes acked", int'(acks), 15);
            check_eq("R6 busy length", len, TWR);
            peek(l, v);
            check_eq("R4 array updated after stop", v, int'(exp_mem[l]));
        end

        // R8: write protect
        wp = 1'b1;
        write_cycle(wdev(strap), 8'h00, 8'h03, 8'h5C, acks, len);
        wp = 1'b0;
        check_eq("R8 bytes acked under write protect", int'(acks), 15);
        check_eq("R8 no busy under write protect", len, 0);
        peek(3, v);
        check_eq("R8 array unchanged under write protect", v, int'(exp_mem[3]));

        // R2: read-select acked, following byte not, no write
        bus_start;
        send_byte({4'b1010, strap, 1'b1}, a);
        check_eq("R2 read-select acked", int'(a), 1);
        send_byte(8'h00, a);
        check_eq("R2 byte after read-select nacked", int'(a), 0);
        bus_stop;
        busy_len(len);
        check_eq("R2 no write after read-select", len, 0);

        // R3: fifth byte nacked, write of fourth still committed
        bus_start;
        send_byte(wdev(strap), a);
        send_byte(8'h00, a);
        send_byte(8'h07, a);
        send_byte(8'hA7, a);
        send_byte(8'h3B, a);
        check_eq("R3 fifth byte nacked", int'(a), 0);
        bus_stop;
        busy_len(len);
        exp_mem[7] = 8'hA7;
        check_eq("R3 busy after extra byte", len, TWR);
        peek(7, v);
        check_eq("R3 data byte kept over extra byte", v, int'(exp_mem[7]));

        // R4: stop before data byte writes nothing
        bus_start;
        send_byte(wdev(strap), a);
        send_byte(8'h00, a);
        send_byte(8'h08, a);
        bus_stop;
        busy_len(len);
        check_eq("R4 no busy without data byte", len, 0);

        // R5: repeated start mid-transfer
        bus_start;
        send_byte(wdev(strap), a);
        send_byte(8'h00, a);
        send_byte(8'h09, a);
        write_cycle(wdev(strap), 8'h00, 8'h0A, 8'hC4, acks, len);
        exp_mem[10] = 8'hC4;
        check_eq("R5 acks after repeated start", int'(acks), 15);
        peek(9, v);
        check_eq("R5 partial transfer discarded", v, int'(exp_mem[9]));
        peek(10, v);
        check_eq("R5 restarted write lands", v, int'(exp_mem[10]));

        // R7: transfer started while busy is ignored
        bus_start;
        send_byte(wdev(strap), a);
        send_byte(8'h00, a);
        send_byte(8'h0C, a);
        send_byte(8'h9E, a);
        bus_stop;
        exp_mem[12] = 8'h9E;
        bus_start;
        check_eq("R7 busy during restart attempt", int'(busy), 1);
        send_byte(wdev(strap), a);
        check_eq("R7 select nacked while busy", int'(a), 0);
        send_byte(8'h00, a);
        check_eq("R7 still nacked after busy ends", int'(a), 0);
        bus_stop;
        busy_len(len);
        check_eq("R7 no write from ignored transfer", len, 0);
        peek(12, v);
        check_eq("R7 write before busy kept", v, int'(exp_mem[12]));

        // R1: mismatch ignores following bytes
        bus_start;
        send_byte(wdev(strap ^ 3'd2), a);
        send_byte(8'h00, a);
        check_eq("R1 bytes after mismatch nacked", int'(a), 0);
        bus_stop;
        busy_len(len);
        check_eq("R1 no write after mismatch", len, 0);

        // final array compare
        for (int i = 0; i < DEPTH; i++) begin
            peek(i, v);
            check_eq("R4 final array contents", v, int'(exp_mem[i]));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule